// File: doc/BRIEF.md
# Inverter Gate-Drive Protection Sequencer

This block sits between six active-high PWM commands and the six gate enables of a three-phase inverter bridge. Each phase has one high-side and one low-side command. Digital comparator flags report three kinds of trouble: the shared low-side supply has dropped too low, the high-side supply of one phase has dropped too low, or the phase current has crossed the trip level. The block turns the affected gates off and, for low-side faults, pulls an active-low fault line for a fixed number of clock cycles.

The fault types are handled differently. A low-side supply drop or an over-current trip turns off all three low-side gates and starts the fault pulse. A high-side supply drop turns off only that phase's high-side gate and does not touch the fault line. Every gate that was forced off, and every gate after reset, stays off until its command makes a new low-to-high transition. While both commands of a phase are high, both gates of that phase are held off, so the leg is never shorted. All timing is counted in clock cycles and set by parameters.

Top module: `gate_guard_seq`

## Requirements
- R1: With no block active, a gate turns on in the clock cycle after its command rises and turns off in the cycle after the command falls. Bit p of each bus belongs to phase p (0 = U, 1 = V, 2 = W).
- R2: After reset all six gates are off and `fault_n` is high. A command held high through reset does not turn its gate on until it falls and rises again.
- R3: While `uv_lo` is high, all three low-side gates are off from the next cycle onward, even when a command rises. The high-side gates are unaffected.
- R4: A rising edge on `uv_lo` or `oc_trip`, seen while no pulse is running, drives `fault_n` low for exactly FAULT_PULSE_CYCLES cycles, starting in the next cycle.
- R5: While `oc_trip` is high, all three low-side gates are off from the next cycle onward, and they stay off after the pulse ends for as long as the flag stays high. The high-side gates are unaffected.
- R6: While `fault_n` is low, no low-side gate is on, even when its command makes a fresh rising edge.
- R7: When a block clears, a gate whose command is already high stays off. It turns on only after the command falls and then rises.
- R8: `uv_hi[p]` turns off only `gate_hi[p]` from the next cycle. It never drives `fault_n` low, and the other five gates keep following their commands.
- R9: A new rising edge of `uv_lo` or `oc_trip` during a running pulse neither restarts nor extends it. The pulse still ends FAULT_PULSE_CYCLES cycles after it started.
- R10: While `cmd_hi[p]` and `cmd_lo[p]` are both high, both gates of phase p are off. After the overlap, each gate of that phase needs a fresh rising edge of its own command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_hi | input | NUM_PHASES | High-side commands, active high |
| cmd_lo | input | NUM_PHASES | Low-side commands, active high |
| uv_lo | input | 1 | Low-side supply undervoltage flag |
| uv_hi | input | NUM_PHASES | High-side supply undervoltage flag, one per phase |
| oc_trip | input | 1 | Over-current trip flag |
| gate_hi | output | NUM_PHASES | High-side gate enables |
| gate_lo | output | NUM_PHASES | Low-side gate enables |
| fault_n | output | 1 | Fault output, active low, driven low for the pulse time |

## Verification
The bench builds the block with FAULT_PULSE_CYCLES set to 8 and NUM_PHASES set to 3. The short pulse lets a few dozen cycles cover the full pulse width, a second fault arriving partway through a pulse, and a fault flag that stays high after the pulse has ended. The last pulse cycle is checked on both sides of the boundary. Keeping all three phases makes it visible that a high-side undervoltage or a leg overlap in one phase leaves the other phases untouched.

// File: rtl/gate_guard_pkg.sv
package gate_guard_pkg;

    // Register state of one gate channel.
    typedef struct packed {
        logic gate;      // registered gate enable
        logic cmd_prev;  // command value seen at the previous edge
    } chan_state_t;

    // Reset value: the command is treated as already high, so a fresh
    // low-to-high transition is needed before the first turn-on.
    localparam chan_state_t CHAN_RESET = '{gate: 1'b0, cmd_prev: 1'b1};

endpackage

// File: rtl/gate_channel.sv
module gate_channel
    import gate_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic block,
    output logic gate
);

    chan_state_t st_d, st_q;
    logic        cmd_rise;

    always_comb begin
        st_d          = st_q;
        cmd_rise      = cmd & ~st_q.cmd_prev;
        // Track the command even while blocked: an edge that arrives
        // during a block is used up and cannot arm the gate later.
        st_d.cmd_prev = cmd;
        st_d.gate     = ~block & cmd & (st_q.gate | cmd_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CHAN_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate = st_q.gate;

    AST_GATE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gate |-> $past(cmd)); // R1

    AST_BLOCK_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> !st_q.gate); // R3

    AST_REARM_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.gate) |-> ($past(cmd) && !$past(cmd, 2) && !$past(block))); // R7

endmodule

// File: rtl/fault_pulse_timer.sv
module fault_pulse_timer #(
    parameter int unsigned PULSE_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_lo,
    input  logic oc_trip,
    output logic pulse_active
);

    localparam int unsigned CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic          uv_prev;
        logic          oc_prev;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       start_evt;

    always_comb begin
        st_d         = st_q;
        start_evt    = (uv_lo & ~st_q.uv_prev) | (oc_trip & ~st_q.oc_prev);
        st_d.uv_prev = uv_lo;
        st_d.oc_prev = oc_trip;
        if (st_q.active) begin
            // A running pulse ignores new start events.
            if (st_q.cnt == '0) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start_evt) begin
            st_d.active = 1'b1;
            st_d.cnt    = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_active = st_q.active;

    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (($rose(uv_lo) || $rose(oc_trip)) && !st_q.active) |=> st_q.active); // R4

    AST_PULSE_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.cnt != '0) |=> (st_q.active && st_q.cnt == $past(st_q.cnt) - CW'(1))); // R9

endmodule

// File: rtl/leg_block_map.sv
module leg_block_map #(
    parameter int unsigned NUM_PHASES = 3
) (
    input  logic [NUM_PHASES-1:0] cmd_hi,
    input  logic [NUM_PHASES-1:0] cmd_lo,
    input  logic [NUM_PHASES-1:0] uv_hi,
    input  logic                  uv_lo,
    input  logic                  oc_trip,
    input  logic                  pulse_active,
    output logic [NUM_PHASES-1:0] blk_hi,
    output logic [NUM_PHASES-1:0] blk_lo
);

    logic lo_shared;

    // The three low-side gates share one supply and one trip path.
    assign lo_shared = uv_lo | oc_trip | pulse_active;

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
        logic overlap;
        assign overlap   = cmd_hi[p] & cmd_lo[p];
        assign blk_hi[p] = uv_hi[p] | overlap;
        assign blk_lo[p] = lo_shared | overlap;
    end

endmodule

// File: rtl/gate_guard_seq.sv
module gate_guard_seq #(
    parameter int unsigned NUM_PHASES         = 3,
    parameter int unsigned FAULT_PULSE_CYCLES = 3000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] cmd_hi,
    input  logic [NUM_PHASES-1:0] cmd_lo,
    input  logic                  uv_lo,
    input  logic [NUM_PHASES-1:0] uv_hi,
    input  logic                  oc_trip,
    output logic [NUM_PHASES-1:0] gate_hi,
    output logic [NUM_PHASES-1:0] gate_lo,
    output logic                  fault_n
);

    logic                  pulse_active;
    logic [NUM_PHASES-1:0] blk_hi;
    logic [NUM_PHASES-1:0] blk_lo;

    fault_pulse_timer #(
        .PULSE_CYCLES(FAULT_PULSE_CYCLES)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .uv_lo        (uv_lo),
        .oc_trip      (oc_trip),
        .pulse_active (pulse_active)
    );

    leg_block_map #(
        .NUM_PHASES(NUM_PHASES)
    ) u_map (
        .cmd_hi       (cmd_hi),
        .cmd_lo       (cmd_lo),
        .uv_hi        (uv_hi),
        .uv_lo        (uv_lo),
        .oc_trip      (oc_trip),
        .pulse_active (pulse_active),
        .blk_hi       (blk_hi),
        .blk_lo       (blk_lo)
    );

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        gate_channel u_hi (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (cmd_hi[p]),
            .block (blk_hi[p]),
            .gate  (gate_hi[p])
        );

        gate_channel u_lo (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (cmd_lo[p]),
            .block (blk_lo[p]),
            .gate  (gate_lo[p])
        );

        AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hi[p] && gate_lo[p])); // R10

        AST_HS_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            uv_hi[p] |=> !gate_hi[p]); // R8
    end

    assign fault_n = ~pulse_active;

    AST_UVLO_LO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        uv_lo |=> (gate_lo == '0)); // R3

    AST_OC_LO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |=> (gate_lo == '0)); // R5

    AST_PULSE_LO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (gate_lo == '0)); // R6

    AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> ($past(uv_lo) || $past(oc_trip))); // R8

endmodule

// File: tb/gate_guard_seq_tb_top.sv
module gate_guard_seq_tb_top;

    localparam int unsigned NPH   = 3;
    localparam int unsigned PULSE = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NPH-1:0] cmd_hi, cmd_lo, uv_hi;
    logic           uv_lo, oc_trip;
    logic [NPH-1:0] gate_hi, gate_lo;
    logic           fault_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [NPH-1:0] gh;
        logic [NPH-1:0] gl;
        logic           fn;
        string          tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    gate_guard_seq #(
        .NUM_PHASES         (NPH),
        .FAULT_PULSE_CYCLES (PULSE)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_hi  (cmd_hi),
        .cmd_lo  (cmd_lo),
        .uv_lo   (uv_lo),
        .uv_hi   (uv_hi),
        .oc_trip (oc_trip),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo),
        .fault_n (fault_n)
    );

    // Driver: apply one cycle of stimulus and queue the outputs expected
    // after the following rising edge.
    task automatic step(input logic [NPH-1:0] h, input logic [NPH-1:0] l,
                        input logic uvl, input logic [NPH-1:0] uvh, input logic oc,
                        input logic [NPH-1:0] egh, input logic [NPH-1:0] egl,
                        input logic efn, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_hi  = h;
        cmd_lo  = l;
        uv_lo   = uvl;
        uv_hi   = uvh;
        oc_trip = oc;
        e.gh  = egh;
        e.gl  = egl;
        e.fn  = efn;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: pop one expectation per cycle, just after the edge.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (gate_hi !== e.gh || gate_lo !== e.gl || fault_n !== e.fn) begin
                failures++;
                $display("FAIL %s: gate_hi=%b gate_lo=%b fault_n=%b, expected %b %b %b",
                         e.tag, gate_hi, gate_lo, fault_n, e.gh, e.gl, e.fn);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        cmd_hi  = 3'b001;
        cmd_lo  = 3'b000;
        uv_hi   = 3'b000;
        uv_lo   = 1'b0;
        oc_trip = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        checks++;
        if (gate_hi !== 3'b000 || gate_lo !== 3'b000 || fault_n !== 1'b1) begin
            failures++;
            $display("FAIL R2 reset: gate_hi=%b gate_lo=%b fault_n=%b, expected 000 000 1",
                     gate_hi, gate_lo, fault_n);
        end

        // R2: command held high through reset stays off
        step(3'b001, 3'b000, 0, 3'b000, 0, 3'b000, 3'b000, 1, "R2 held through reset");
        // R1: normal following
        step(3'b000, 3'b000, 0, 3'b000, 0, 3'b000, 3'b000, 1, "R1 low");
        step(3'b001, 3'b000, 0, 3'b000, 0, 3'b001, 3'b000, 1, "R1 hi rise");
        step(3'b001, 3'b010, 0, 3'b000, 0, 3'b001, 3'b010, 1, "R1 lo rise");
        // R10: leg overlap on phase 1
        step(3'b011, 3'b010, 0, 3'b000, 0, 3'b001, 3'b000, 1, "R10 overlap");
        step(3'b001, 3'b010, 0, 3'b000, 0, 3'b001, 3'b000, 1, "R10 needs edge");
        step(3'b001, 3'b000, 0, 3'b000, 0, 3'b001, 3'b000, 1, "R10 low");
        step(3'b001, 3'b010, 0, 3'b000, 0, 3'b001, 3'b010, 1, "R10 re-armed");

        // R3/R4: one-cycle low-side undervoltage
        step(3'b001, 3'b010, 1, 3'b000, 0, 3'b001, 3'b000, 0, "R3 uv_lo blocks");
        step(3'b001, 3'b010, 0, 3'b000, 0, 3'b001, 3'b000, 0, "R4 pulse");
        step(3'b001, 3'b000, 0, 3'b000, 0, 3'b001, 3'b000, 0, "R4 pulse");
        step(3'b001, 3'b010, 0, 3'b000, 0, 3'b001, 3'b000, 0, "R6 edge during pulse");
        step(3'b001, 3'b010, 0, 3'b000, 1, 3'b001, 3'b000, 0, "R9 trip during pulse");
        for (int i = 0; i < 3; i++)
            step(3'b001, 3'b010, 0, 3'b000, 0, 3'b001, 3'b000, 0, "R9 pulse holds");
        step(3'b001, 3'b010, 0, 3'b000, 0, 3'b001, 3'b000, 1, "R9 pulse ends on time");
        step(3'b001, 3'b010, 0, 3'b000, 0, 3'b001, 3'b000, 1, "R7 held high stays off");
        step(3'b001, 3'b000, 0, 3'b000, 0, 3'b001, 3'b000, 1, "R7 low");
        step(3'b001, 3'b010, 0, 3'b000, 0, 3'b001, 3'b010, 1, "R7 fresh edge");

        // R5/R4: over-current held longer than the pulse
        for (int i = 0; i < PULSE; i++)
            step(3'b001, 3'b010, 0, 3'b000, 1, 3'b001, 3'b000, 0, "R5 trip pulse");
        for (int i = 0; i < 2; i++)
            step(3'b001, 3'b010, 0, 3'b000, 1, 3'b001, 3'b000, 1, "R5 trip level blocks");
        step(3'b001, 3'b010, 0, 3'b000, 0, 3'b001, 3'b000, 1, "R7 after trip");
        step(3'b001, 3'b000, 0, 3'b000, 0, 3'b001, 3'b000, 1, "R7 low");
        step(3'b001, 3'b010, 0, 3'b000, 0, 3'b001, 3'b010, 1, "R7 fresh edge");

        // R8: high-side undervoltage on phase 0 only
        step(3'b001, 3'b010, 0, 3'b001, 0, 3'b000, 3'b010, 1, "R8 hs uv local");
        step(3'b101, 3'b010, 0, 3'b001, 0, 3'b100, 3'b010, 1, "R8 other phase free");
        step(3'b101, 3'b010, 0, 3'b000, 0, 3'b100, 3'b010, 1, "R7 hs held high");
        step(3'b100, 3'b010, 0, 3'b000, 0, 3'b100, 3'b010, 1, "R8 low");
        step(3'b101, 3'b010, 0, 3'b000, 0, 3'b101, 3'b010, 1, "R8 re-armed");

        // R3: undervoltage held past the pulse
        for (int i = 0; i < PULSE; i++)
            step(3'b101, 3'b010, 1, 3'b000, 0, 3'b101, 3'b000, 0, "R3 uv_lo level");
        step(3'b101, 3'b000, 1, 3'b000, 0, 3'b101, 3'b000, 1, "R4 pulse width");
        step(3'b101, 3'b010, 1, 3'b000, 0, 3'b101, 3'b000, 1, "R3 edge under uv_lo");
        step(3'b101, 3'b010, 0, 3'b000, 0, 3'b101, 3'b000, 1, "R7 after uv_lo");
        step(3'b101, 3'b000, 0, 3'b000, 0, 3'b101, 3'b000, 1, "R1 low");
        step(3'b101, 3'b010, 0, 3'b000, 0, 3'b101, 3'b010, 1, "R1 recovered");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule